// File: doc/BRIEF.md
# Software Interrupt Target Dispatcher

This block takes one 32-bit write that asks for a software-generated interrupt, along with the number of the processor that made the request. It pulls four fields out of the word: the interrupt number, a security bit, a two-bit routing mode and an eight-bit destination bitmap. From these it works out which CPU interfaces should receive the interrupt. On each chosen interface it raises the pending flag for that interrupt number and stores the requester's number and the security bit next to the flag.

Every implemented CPU interface has sixteen pending flags, one for each interrupt number. An interface takes down one of its flags by presenting an acknowledge with the interrupt number. A global forwarding enable can block all routing. When it is low, writes are still taken but change nothing.

Top module: `sgi_dispatch`

## Requirements
- R1: Field positions in the write word are: routing mode in bits 25:24, destination bitmap in bits 23:16, security bit in bit 15, interrupt number in bits 3:0. With routing mode 0, the flag for that interrupt number is raised on every interface n whose bitmap bit 16+n is 1. The flag is visible on the clock after the write.
- R2: In routing mode 0, a bitmap of 0x00 raises no flag on any interface.
- R3: Routing mode 1 raises the flag on every implemented interface except the one whose index equals the requester number.
- R4: Routing mode 2 raises the flag only on the interface whose index equals the requester number.
- R5: A write with routing mode 3 changes no pending flag, stored requester number or stored security bit.
- R6: While the forwarding enable is low, a write changes no pending flag, stored requester number or stored security bit.
- R7: Each raised flag stores the security bit of the write that raised it.
- R8: A write aimed at a flag that is already pending leaves the flag set. It replaces the stored requester number and security bit with those of the new write.
- R9: An acknowledge on interface n with interrupt number k clears flag k of interface n on the next clock and leaves all other flags unchanged.
- R10: If a write raises flag k on interface n in the same cycle that interface n acknowledges k, the flag is set afterwards.
- R11: No interface at or above NUM_CPU receives an interrupt in any routing mode. A requester number at or above NUM_CPU selects no interface in mode 2.
- R12: After reset, every pending flag, stored requester number and stored security bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fwd_en | input | 1 | Global forwarding enable |
| wr_valid | input | 1 | A request write is present this cycle |
| wr_data | input | 32 | Request word |
| wr_src | input | 3 | Number of the requesting processor |
| ack_valid | input | NUM_CPU | Per-interface acknowledge strobe |
| ack_id | input | NUM_CPU*4 | Per-interface acknowledged interrupt number, interface n at bits 4n+3:4n |
| pend | output | NUM_CPU*16 | Pending flags, interface n interrupt k at bit 16n+k |
| pend_src | output | NUM_CPU*48 | Stored requester number, 3 bits per flag, flag 16n+k at bits 3(16n+k)+2:3(16n+k) |
| pend_sec | output | NUM_CPU*16 | Stored security bit, same bit order as pend |

## Verification
Every result depends on one register stage. A write or an acknowledge presented before clock edge t shows up on the outputs just after edge t, and nothing before that edge changes. The bench drives inputs on the falling edge and steps its behavioural model at the rising edge. It compares the full pending, requester and security vectors one time unit after each rising edge, so every result is checked in the cycle it falls due. The no-effect cases (mode 3, forwarding disabled, interfaces not implemented) are checked the same way: the unchanged vectors are compared in the cycle right after the write.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    localparam int ID_W    = 4;
    localparam int NUM_ID  = 1 << ID_W;
    localparam int SRC_W   = 3;
    localparam int MAX_CPU = 1 << SRC_W;

    // routing mode encoding; values are decoded from the write word
    typedef enum logic [1:0] {
        ROUTE_LIST   = 2'd0,
        ROUTE_OTHERS = 2'd1,
        ROUTE_SELF   = 2'd2,
        ROUTE_RSVD   = 2'd3
    } route_e;

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic             sec;
        logic [SRC_W-1:0] src;
    } sgi_req_t;

    // field positions inside the request word
    localparam int MODE_LSB = 24;
    localparam int LIST_LSB = 16;
    localparam int SEC_BIT  = 15;
    localparam int ID_LSB   = 0;

endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fwd_en,
    input  logic               wr_valid,
    input  logic [31:0]        wr_data,
    input  logic [SRC_W-1:0]   wr_src,
    output sgi_req_t           req,
    output logic [NUM_CPU-1:0] tgt
);

    localparam logic [MAX_CPU-1:0] IMPL_MASK =
        MAX_CPU'((9'd1 << NUM_CPU) - 9'd1);

    route_e             mode;
    logic [MAX_CPU-1:0] list;
    logic [MAX_CPU-1:0] self_bit;
    logic [MAX_CPU-1:0] pick;
    logic [MAX_CPU-1:0] full_tgt;

    always_comb begin
        mode     = route_e'(wr_data[MODE_LSB +: 2]);
        list     = wr_data[LIST_LSB +: MAX_CPU];
        self_bit = MAX_CPU'(1) << wr_src;
        req.id   = wr_data[ID_LSB +: ID_W];
        req.sec  = wr_data[SEC_BIT];
        req.src  = wr_src;
        unique case (mode)
            ROUTE_LIST:   pick = list;
            ROUTE_OTHERS: pick = ~self_bit;
            ROUTE_SELF:   pick = self_bit;
            default:      pick = '0;
        endcase
        full_tgt = (wr_valid && fwd_en) ? (pick & IMPL_MASK) : '0;
        tgt      = full_tgt[NUM_CPU-1:0];
    end

    AST_RSVD_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data[MODE_LSB +: 2] == 2'd3) |-> (tgt == '0)); // R5
    AST_FWD_OFF_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_en |-> (tgt == '0)); // R6
    AST_SELF_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data[MODE_LSB +: 2] == 2'd2) |-> $onehot0(tgt)); // R4
    AST_OTHERS_SKIP_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data[MODE_LSB +: 2] == 2'd1 && int'(wr_src) < NUM_CPU)
        |-> !tgt[wr_src]); // R3
    AST_NO_IDLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> (tgt == '0)); // R1

endmodule

// File: rtl/sgi_cpu_bank.sv
module sgi_cpu_bank
    import sgi_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_hit,
    input  sgi_req_t                req,
    input  logic                    ack_valid,
    input  logic [ID_W-1:0]         ack_id,
    output logic [NUM_ID-1:0]       pend_o,
    output logic [NUM_ID*SRC_W-1:0] src_o,
    output logic [NUM_ID-1:0]       sec_o
);

    typedef struct packed {
        logic [NUM_ID-1:0]            pend;
        logic [NUM_ID-1:0][SRC_W-1:0] src;
        logic [NUM_ID-1:0]            sec;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack_valid) begin
            st_d.pend[ack_id] = 1'b0;
        end
        // a set in the same cycle wins over the acknowledge
        if (set_hit) begin
            st_d.pend[req.id] = 1'b1;
            st_d.src[req.id]  = req.src;
            st_d.sec[req.id]  = req.sec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign src_o  = st_q.src;
    assign sec_o  = st_q.sec;

    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> pend_o[$past(req.id)]); // R1
    AST_SET_RECORDS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> (sec_o[$past(req.id)] == $past(req.sec))); // R7
    AST_SET_RECORDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> (src_o[$past(req.id)*SRC_W +: SRC_W] == $past(req.src))); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !(set_hit && req.id == ack_id))
        |=> !pend_o[$past(ack_id)]); // R9
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_hit && !ack_valid) |=> ($stable(pend_o) && $stable(src_o) && $stable(sec_o))); // R6

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fwd_en,
    input  logic                        wr_valid,
    input  logic [31:0]                 wr_data,
    input  logic [2:0]                  wr_src,
    input  logic [NUM_CPU-1:0]          ack_valid,
    input  logic [NUM_CPU*4-1:0]        ack_id,
    output logic [NUM_CPU*16-1:0]       pend,
    output logic [NUM_CPU*48-1:0]       pend_src,
    output logic [NUM_CPU*16-1:0]       pend_sec
);

    localparam int SRC_SLICE = NUM_ID * SRC_W;

    sgi_req_t           req;
    logic [NUM_CPU-1:0] tgt;

    sgi_target_decode #(
        .NUM_CPU (NUM_CPU)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .fwd_en   (fwd_en),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .wr_src   (wr_src),
        .req      (req),
        .tgt      (tgt)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
        sgi_cpu_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_hit   (tgt[c]),
            .req       (req),
            .ack_valid (ack_valid[c]),
            .ack_id    (ack_id[c*ID_W +: ID_W]),
            .pend_o    (pend[c*NUM_ID +: NUM_ID]),
            .src_o     (pend_src[c*SRC_SLICE +: SRC_SLICE]),
            .sec_o     (pend_sec[c*NUM_ID +: NUM_ID])
        );
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $rose(rst_n) |-> (pend == '0 && pend_src == '0 && pend_sec == '0)); // R12
    AST_RSVD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_data[25:24] == 2'd3 && ack_valid == '0)
        |=> ($stable(pend) && $stable(pend_src) && $stable(pend_sec))); // R5

endmodule

// File: tb/sim_sgi_dispatch.sv
module sim_sgi_dispatch;

    localparam int NC = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fwd_en = 1'b1;
    logic              wr_valid = 1'b0;
    logic [31:0]       wr_data = '0;
    logic [2:0]        wr_src = '0;
    logic [NC-1:0]     ack_valid = '0;
    logic [NC*4-1:0]   ack_id = '0;
    logic [NC*16-1:0]  pend;
    logic [NC*48-1:0]  pend_src;
    logic [NC*16-1:0]  pend_sec;

    int    checks = 0;
    int    errors = 0;
    string tag = "R12";

    bit m_pend [NC][16];
    bit m_sec  [NC][16];
    int m_src  [NC][16];

    always #10 clk = ~clk;

    sgi_dispatch #(.NUM_CPU(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_src(wr_src), .ack_valid(ack_valid),
        .ack_id(ack_id), .pend(pend), .pend_src(pend_src), .pend_sec(pend_sec)
    );

    function automatic logic [31:0] word(int mode, int list, int sec, int id);
        return (32'(mode) << 24) | (32'(list) << 16) | (32'(sec) << 15) | 32'(id);
    endfunction

    // behavioural reference: applied at each rising edge
    task automatic model_edge();
        int mode, id, sec, src;
        mode = int'(wr_data[25:24]);
        id   = int'(wr_data[3:0]);
        sec  = int'(wr_data[15]);
        src  = int'(wr_src);
        for (int c = 0; c < NC; c++) begin
            bit hit;
            if (ack_valid[c]) m_pend[c][int'(ack_id[c*4 +: 4])] = 1'b0;
            case (mode)
                0: hit = wr_data[16+c];
                1: hit = (c != src);
                2: hit = (c == src);
                default: hit = 1'b0;
            endcase
            if (wr_valid && fwd_en && hit) begin
                m_pend[c][id] = 1'b1;
                m_sec[c][id]  = sec[0];
                m_src[c][id]  = src;
            end
        end
    endtask

    task automatic compare();
        logic [NC*16-1:0] ep, es;
        logic [NC*48-1:0] er;
        for (int c = 0; c < NC; c++) begin
            for (int k = 0; k < 16; k++) begin
                ep[c*16+k] = m_pend[c][k];
                es[c*16+k] = m_sec[c][k];
                er[(c*16+k)*3 +: 3] = 3'(m_src[c][k]);
            end
        end
        checks += 3;
        if (pend !== ep) begin
            errors++;
            $display("FAIL %s pend actual %h expected %h", tag, pend, ep);
        end
        if (pend_sec !== es) begin
            errors++;
            $display("FAIL %s pend_sec actual %h expected %h", tag, pend_sec, es);
        end
        if (pend_src !== er) begin
            errors++;
            $display("FAIL %s pend_src actual %h expected %h", tag, pend_src, er);
        end
    endtask

    task automatic step(input logic wv, input logic [31:0] d, input logic [2:0] s,
                        input logic [NC-1:0] av, input logic [NC*4-1:0] ai);
        @(negedge clk);
        wr_valid  = wv;
        wr_data   = d;
        wr_src    = s;
        ack_valid = av;
        ack_id    = ai;
        @(posedge clk);
        model_edge();
        #1;
        compare();
    endtask

    task automatic idle();
        step(1'b0, '0, '0, '0, '0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < 16; k++) begin
                m_pend[c][k] = 0; m_sec[c][k] = 0; m_src[c][k] = 0;
            end
        repeat (3) @(posedge clk);
        #1;
        tag = "R12"; compare();
        @(negedge clk); rst_n = 1'b1;
        tag = "R12"; idle();

        tag = "R1"; step(1'b1, word(0, 8'h05, 0, 3), 3'd1, '0, '0);
        tag = "R7"; step(1'b1, word(0, 8'h2A, 1, 7), 3'd0, '0, '0);
        tag = "R2"; step(1'b1, word(0, 8'h00, 1, 9), 3'd2, '0, '0);
        tag = "R3"; step(1'b1, word(1, 8'h00, 0, 4), 3'd2, '0, '0);
        tag = "R4"; step(1'b1, word(2, 8'h00, 1, 11), 3'd5, '0, '0);
        tag = "R5"; step(1'b1, word(3, 8'hFF, 1, 12), 3'd0, '0, '0);
        fwd_en = 1'b0;
        tag = "R6"; step(1'b1, word(0, 8'hFF, 1, 13), 3'd3, '0, '0);
        tag = "R6"; step(1'b1, word(1, 8'h00, 1, 13), 3'd3, '0, '0);
        fwd_en = 1'b1;
        tag = "R11"; step(1'b1, word(0, 8'hC0, 1, 14), 3'd1, '0, '0);
        tag = "R11"; step(1'b1, word(2, 8'h00, 1, 1), 3'd7, '0, '0);
        tag = "R11"; step(1'b1, word(1, 8'h00, 1, 2), 3'd7, '0, '0);
        tag = "R8"; step(1'b1, word(0, 8'h01, 1, 3), 3'd4, '0, '0);
        tag = "R9"; step(1'b0, '0, '0, 6'b000100, 24'h000300);
        tag = "R9"; step(1'b0, '0, '0, 6'b100001, 24'h400003);
        tag = "R10"; step(1'b1, word(0, 8'h01, 0, 5), 3'd3, 6'b000001, 24'h000005);
        tag = "R9"; step(1'b0, '0, '0, 6'b000001, 24'h000005);
        tag = "R10"; step(1'b1, word(1, 8'h00, 1, 6), 3'd0, 6'b111110, 24'h666660);
        tag = "R9"; idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule